// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the hardware half of a receive descriptor ring for an Ethernet MAC. A small internal table holds `RING_DEPTH` descriptors. Each descriptor has a 16-bit status word, a 16-bit length and a 32-bit buffer pointer. The MAC reports each completed frame on a one-cycle input that carries the byte count and an error flag. The engine places that report into the descriptor at its current index and hands the descriptor to software by clearing its ownership flag. It then moves on to the next descriptor. When the descriptor it just used has its wrap flag set, the engine goes back to descriptor 0 instead of moving forward.

Software reaches the table through a simple register port: a descriptor index, a field select and write data, with a combinational read-back. To re-arm a descriptor, software writes the ownership flag (and the wrap flag on the final entry) and a zero length. It then pulses `kick_i`. The engine stalls as soon as it faces a descriptor it does not own. While it is stalled, every incoming frame report is discarded and flagged. The stall lasts until the kick arrives.

The control state machine has two states. READY waits for frames. STALL waits for the kick. There are four transitions:
- READY→READY (accept): a frame arrives and the current descriptor is owned.
- READY→STALL (not owned): the current descriptor is not owned, with or without a frame arriving.
- STALL→READY (kick): `kick_i` is high.
- STALL→STALL (hold): anything else while stalled.

Top module: `rxr_ring_engine`

## Requirements
- R1: After reset the ring index is 0 and the engine is not stalled. Every descriptor reads status 0x8000 (owned flag, bit 15), except the last, which reads 0xA000 (owned plus wrap flag, bit 13). All lengths read 0.
- R2: An accepted frame stores in the length field the reported byte count plus the 4-byte frame check sequence.
- R3: An accepted frame rewrites the status word as follows. Bit 15 (owned) is cleared. Bit 11 (last-of-frame) is set. Bit 1 (error) copies `frm_err_i`. Bit 13 (wrap) keeps its previous value. Every other bit is 0.
- R4: `done_o` is high for exactly the one cycle after each accepted frame.
- R5: After an accept, the index moves to the next descriptor. It returns to 0 if the used descriptor had its wrap flag set, or if it was the last slot.
- R6: While the descriptor at the index does not have the owned flag set, the engine enters STALL (`stalled_o` high) one cycle later and stays there until kicked.
- R7: A frame that arrives while stalled, or that meets a descriptor that is not owned, is dropped. A drop raises `overrun_o` for one cycle, does not raise `done_o`, and leaves the table and the index unchanged.
- R8: `kick_i` moves STALL to READY. If the descriptor is still not owned, the engine stalls again one cycle later.
- R9: The software port writes and reads the status (select 0), length (select 1) and pointer (select 2) fields. The engine never changes the pointer field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid_i | input | 1 | One-cycle frame completion strobe |
| frm_len_i | input | 16 | Frame byte count without check sequence |
| frm_err_i | input | 1 | Frame received with error |
| kick_i | input | 1 | Resume strobe from software |
| sw_we_i | input | 1 | Software table write enable |
| sw_idx_i | input | IDX_W | Software descriptor index |
| sw_fld_i | input | 2 | Field select: 0 status, 1 length, 2 pointer |
| sw_wdata_i | input | 32 | Software write data |
| sw_rdata_o | output | 32 | Selected field of selected descriptor |
| done_o | output | 1 | Descriptor handed back to software |
| overrun_o | output | 1 | Frame dropped |
| stalled_o | output | 1 | Engine in STALL |
| ring_idx_o | output | IDX_W | Current ring index |

## Verification
A table of four frames walks the whole default ring. The frames mix the error flag and the lengths. This shows that the length offset, the error bit and the preserved wrap bit are written to the right entry at the right index.

Frames are also offered in two drop situations: while the engine is stalled, and in the first cycle after a kick that lands on a descriptor that is still not owned. These two cases separate a drop in the STALL state from a drop in the READY state.

Finally, software moves the wrap flag to descriptor 1. This shows that the return to 0 follows the stored flag rather than a count.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int STAT_W = 16;
    localparam int LEN_W  = 16;
    localparam int PTR_W  = 32;

    localparam int OWN_BIT  = 15;
    localparam int WRAP_BIT = 13;
    localparam int LAST_BIT = 11;
    localparam int ERR_BIT  = 1;

    typedef enum logic [1:0] {
        FLD_STATUS  = 2'd0,
        FLD_LENGTH  = 2'd1,
        FLD_POINTER = 2'd2
    } fld_e;

    typedef enum logic {
        ENG_READY = 1'b0,
        ENG_STALL = 1'b1
    } eng_state_e;

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [LEN_W-1:0]  length;
        logic [PTR_W-1:0]  pointer;
    } desc_t;
endpackage

// File: rtl/rxr_desc_table.sv
module rxr_desc_table
    import rxr_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 eng_we,
    input  logic [IDX_W-1:0]     eng_idx,
    input  logic [STAT_W-1:0]    eng_status,
    input  logic [LEN_W-1:0]     eng_length,
    output desc_t                eng_desc,
    input  logic                 sw_we,
    input  logic [IDX_W-1:0]     sw_idx,
    input  logic [1:0]           sw_fld,
    input  logic [PTR_W-1:0]     sw_wdata,
    output logic [PTR_W-1:0]     sw_rdata
);
    desc_t tbl_q [DEPTH];
    fld_e  fld;

    assign fld = fld_e'(sw_fld);

    always_ff @(posedge clk) begin
        for (int e = 0; e < DEPTH; e++) begin
            if (!rst_n) begin
                tbl_q[e].status            <= '0;
                tbl_q[e].status[OWN_BIT]   <= 1'b1;
                tbl_q[e].status[WRAP_BIT]  <= (e == DEPTH - 1);
                tbl_q[e].length            <= '0;
                tbl_q[e].pointer           <= '0;
            end else begin
                if (eng_we && (int'(eng_idx) == e)) begin
                    tbl_q[e].status <= eng_status;
                    tbl_q[e].length <= eng_length;
                end else if (sw_we && (int'(sw_idx) == e)) begin
                    if (fld == FLD_STATUS) tbl_q[e].status <= sw_wdata[STAT_W-1:0];
                    if (fld == FLD_LENGTH) tbl_q[e].length <= sw_wdata[LEN_W-1:0];
                end
                if (sw_we && (int'(sw_idx) == e) && (fld == FLD_POINTER))
                    tbl_q[e].pointer <= sw_wdata;
            end
        end
    end

    assign eng_desc = tbl_q[eng_idx];

    always_comb begin
        unique case (fld)
            FLD_STATUS:  sw_rdata = {{(PTR_W-STAT_W){1'b0}}, tbl_q[sw_idx].status};
            FLD_LENGTH:  sw_rdata = {{(PTR_W-LEN_W){1'b0}}, tbl_q[sw_idx].length};
            FLD_POINTER: sw_rdata = tbl_q[sw_idx].pointer;
            default:     sw_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rxr_idx_step.sv
module rxr_idx_step #(
    parameter int DEPTH = 4,
    parameter int IDX_W = 2
) (
    input  logic [IDX_W-1:0] cur_idx,
    input  logic             wrap_flag,
    output logic [IDX_W-1:0] next_idx
);
    localparam int LAST_SLOT = DEPTH - 1;

    always_comb begin
        if (wrap_flag || (int'(cur_idx) >= LAST_SLOT))
            next_idx = '0;
        else
            next_idx = cur_idx + IDX_W'(1);
    end
endmodule

// File: rtl/rxr_engine_fsm.sv
module rxr_engine_fsm
    import rxr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frm_valid,
    input  logic cur_owned,
    input  logic kick,
    output logic accept,
    output logic stalled,
    output logic done_q,
    output logic overrun_q
);
    eng_state_e state_q, state_d;
    logic       drop;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENG_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        drop    = 1'b0;
        unique case (state_q)
            ENG_READY: begin
                if (cur_owned) begin
                    accept = frm_valid;
                end else begin
                    drop    = frm_valid;
                    state_d = ENG_STALL;
                end
            end
            ENG_STALL: begin
                drop = frm_valid;
                if (kick) state_d = ENG_READY;
            end
            default: state_d = ENG_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            overrun_q <= 1'b0;
        end else begin
            done_q    <= accept;
            overrun_q <= drop;
        end
    end

    assign stalled = (state_q == ENG_STALL);
endmodule

// File: rtl/rxr_ring_engine.sv
module rxr_ring_engine
    import rxr_pkg::*;
#(
    parameter int RING_DEPTH = 4,
    parameter int FCS_BYTES  = 4,
    localparam int IDX_W     = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frm_valid_i,
    input  logic [15:0]          frm_len_i,
    input  logic                 frm_err_i,
    input  logic                 kick_i,
    input  logic                 sw_we_i,
    input  logic [IDX_W-1:0]     sw_idx_i,
    input  logic [1:0]           sw_fld_i,
    input  logic [31:0]          sw_wdata_i,
    output logic [31:0]          sw_rdata_o,
    output logic                 done_o,
    output logic                 overrun_o,
    output logic                 stalled_o,
    output logic [IDX_W-1:0]     ring_idx_o
);
    logic [IDX_W-1:0]  idx_q, idx_nxt;
    desc_t             cur_desc;
    logic              accept;
    logic [STAT_W-1:0] fill_status;
    logic [LEN_W-1:0]  fill_length;

    always_comb begin
        fill_status           = '0;
        fill_status[WRAP_BIT] = cur_desc.status[WRAP_BIT];
        fill_status[LAST_BIT] = 1'b1;
        fill_status[ERR_BIT]  = frm_err_i;
    end

    assign fill_length = frm_len_i + LEN_W'(FCS_BYTES);

    rxr_desc_table #(.DEPTH(RING_DEPTH), .IDX_W(IDX_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .eng_we     (accept),
        .eng_idx    (idx_q),
        .eng_status (fill_status),
        .eng_length (fill_length),
        .eng_desc   (cur_desc),
        .sw_we      (sw_we_i),
        .sw_idx     (sw_idx_i),
        .sw_fld     (sw_fld_i),
        .sw_wdata   (sw_wdata_i),
        .sw_rdata   (sw_rdata_o)
    );

    rxr_idx_step #(.DEPTH(RING_DEPTH), .IDX_W(IDX_W)) u_step (
        .cur_idx   (idx_q),
        .wrap_flag (cur_desc.status[WRAP_BIT]),
        .next_idx  (idx_nxt)
    );

    rxr_engine_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_valid (frm_valid_i),
        .cur_owned (cur_desc.status[OWN_BIT]),
        .kick      (kick_i),
        .accept    (accept),
        .stalled   (stalled_o),
        .done_q    (done_o),
        .overrun_q (overrun_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (accept) idx_q <= idx_nxt;
    end

    assign ring_idx_o = idx_q;
endmodule

// File: rtl/rxr_ring_chk.sv
module rxr_ring_chk #(
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frm_valid_i,
    input logic             kick_i,
    input logic             done_o,
    input logic             overrun_o,
    input logic             stalled_o,
    input logic [IDX_W-1:0] ring_idx_o
);
    // R4
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(frm_valid_i));

    // R5
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(ring_idx_o));

    // R6
    stall_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stalled_o |=> !done_o);

    // R7
    drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stalled_o && frm_valid_i) |=> overrun_o);

    // R8
    stall_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stalled_o && !kick_i) |=> stalled_o);
endmodule

bind rxr_ring_engine rxr_ring_chk #(.IDX_W(IDX_W)) u_ring_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frm_valid_i (frm_valid_i),
    .kick_i      (kick_i),
    .done_o      (done_o),
    .overrun_o   (overrun_o),
    .stalled_o   (stalled_o),
    .ring_idx_o  (ring_idx_o)
);

// File: tb/rxr_ring_engine_tb.sv
module rxr_ring_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_valid_i = 1'b0;
    logic [15:0] frm_len_i = '0;
    logic        frm_err_i = 1'b0;
    logic        kick_i = 1'b0;
    logic        sw_we_i = 1'b0;
    logic [1:0]  sw_idx_i = '0;
    logic [1:0]  sw_fld_i = '0;
    logic [31:0] sw_wdata_i = '0;
    logic [31:0] sw_rdata_o;
    logic        done_o, overrun_o, stalled_o;
    logic [1:0]  ring_idx_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rxr_ring_engine dut_i (
        .clk(clk), .rst_n(rst_n), .frm_valid_i(frm_valid_i), .frm_len_i(frm_len_i),
        .frm_err_i(frm_err_i), .kick_i(kick_i), .sw_we_i(sw_we_i), .sw_idx_i(sw_idx_i),
        .sw_fld_i(sw_fld_i), .sw_wdata_i(sw_wdata_i), .sw_rdata_o(sw_rdata_o),
        .done_o(done_o), .overrun_o(overrun_o), .stalled_o(stalled_o),
        .ring_idx_o(ring_idx_o)
    );

    typedef struct packed {
        logic [15:0] len;
        logic        err;
        logic [15:0] exp_status;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{16'd60,   1'b0, 16'h0800},
        '{16'd1514, 1'b1, 16'h0802},
        '{16'd0,    1'b0, 16'h0800},
        '{16'd100,  1'b1, 16'h2802}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input int idx, input int fld, output logic [31:0] val);
        sw_idx_i = 2'(idx);
        sw_fld_i = 2'(fld);
        #1;
        val = sw_rdata_o;
    endtask

    task automatic wr(input int idx, input int fld, input logic [31:0] val);
        @(negedge clk);
        sw_we_i = 1'b1; sw_idx_i = 2'(idx); sw_fld_i = 2'(fld); sw_wdata_i = val;
        @(negedge clk);
        sw_we_i = 1'b0;
    endtask

    task automatic send(input logic [15:0] len, input logic err);
        @(negedge clk);
        frm_valid_i = 1'b1; frm_len_i = len; frm_err_i = err;
        @(negedge clk);
        frm_valid_i = 1'b0;
    endtask

    task automatic kick();
        @(negedge clk);
        kick_i = 1'b1;
        @(negedge clk);
        kick_i = 1'b0;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 idx", 32'(ring_idx_o), 0);
        chk("R1 stalled", 32'(stalled_o), 0);
        rd(0, 0, v); chk("R1 status0", v, 32'h8000);
        rd(2, 0, v); chk("R1 status2", v, 32'h8000);
        rd(3, 0, v); chk("R1 status3", v, 32'hA000);
        rd(0, 1, v); chk("R1 length0", v, 0);
        wr(2, 2, 32'hDEADBEEF);
        rd(2, 2, v); chk("R9 pointer write", v, 32'hDEADBEEF);

        for (int i = 0; i < 4; i++) begin
            send(VECS[i].len, VECS[i].err);
            chk("R4 done high", 32'(done_o), 1);
            chk("R7 no overrun", 32'(overrun_o), 0);
            rd(i, 0, v); chk("R3 status", v, 32'(VECS[i].exp_status));
            rd(i, 1, v); chk("R2 length", v, 32'(VECS[i].len) + 4);
            chk("R5 index", 32'(ring_idx_o), 32'((i + 1) % 4));
            @(negedge clk);
            chk("R4 done single", 32'(done_o), 0);
        end
        rd(2, 2, v); chk("R9 pointer kept", v, 32'hDEADBEEF);
        chk("R6 stalled", 32'(stalled_o), 1);

        // R7 drop while stalled
        send(16'd500, 1'b0);
        chk("R7 overrun", 32'(overrun_o), 1);
        chk("R7 no done", 32'(done_o), 0);
        rd(0, 1, v); chk("R7 length kept", v, 64);
        chk("R7 index kept", 32'(ring_idx_o), 0);

        // R8 kick without re-arm, frame met in READY on unowned entry
        @(negedge clk);
        kick_i = 1'b1;
        @(negedge clk);
        kick_i = 1'b0;
        chk("R8 left stall", 32'(stalled_o), 0);
        frm_valid_i = 1'b1; frm_len_i = 16'd77; frm_err_i = 1'b0;
        @(negedge clk);
        frm_valid_i = 1'b0;
        chk("R7 drop in ready", 32'(overrun_o), 1);
        chk("R8 restall", 32'(stalled_o), 1);
        rd(0, 0, v); chk("R7 status kept", v, 32'h0800);

        // re-arm entry 0 and resume
        wr(0, 0, 32'h8000);
        wr(0, 1, 0);
        kick();
        chk("R8 resumed", 32'(stalled_o), 0);
        send(16'd200, 1'b0);
        chk("R4 done after kick", 32'(done_o), 1);
        rd(0, 1, v); chk("R2 length 204", v, 204);
        chk("R5 index 1", 32'(ring_idx_o), 1);

        // move wrap flag to entry 1
        wr(1, 0, 32'hA000);
        wr(1, 1, 0);
        rd(1, 0, v); chk("R9 status write", v, 32'hA000);
        kick();
        send(16'd32, 1'b1);
        rd(1, 0, v); chk("R3 wrap kept", v, 32'h2802);
        rd(1, 1, v); chk("R2 length 36", v, 36);
        chk("R5 wrap by flag", 32'(ring_idx_o), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule